// File: doc/BRIEF.md
# Periodic Down-Counter Tick Timer

This block is a 24-bit reloadable down-counter that produces a periodic tick interrupt for a processor subsystem. Software programs a period through a reload register, selects whether the counter advances on every system clock or on rising edges of a slower external reference clock, and enables counting. Each time the count steps from 1 to 0 the block raises a sticky status flag and, if interrupts are enabled, a one-cycle interrupt pulse. On the next counting step it reloads the period value, so a reload of N-1 gives one event every N counting steps.

Software reaches three registers through a plain synchronous strobe interface: a control/status register, a reload register and a current-value register. Read data is combinational and valid in the cycle `reg_rd` is high. A read of the control/status register returns the flag and clears it at the end of that cycle. Writing anything to the current-value register zeroes the counter and the flag. There is no streaming data path and no back-pressure: every access completes in the cycle it is presented.

The external reference clock is treated as an asynchronous input. It passes through a synchronizer and an edge detector, which turn each of its rising edges into a single-cycle count enable in the system clock domain.

Top module: `tick_timer`

## Requirements
- R1: After reset all three registers read zero and `tick_irq` is low.
- R2: Register word addresses on `reg_addr` are 0 = control/status, 1 = reload, 2 = current value, and 3 reads zero. In control/status, bit 0 enables counting, bit 1 enables the interrupt, bit 2 selects the source (1 = system clock, 0 = external reference) and bit 16 is the sticky flag. Every other bit reads zero, and writes to bit 16 are ignored.
- R3: While bit 0 is 0 the count holds its value.
- R4: With source 1 and enable 1, the count falls by one every clock and loads the reload value on the step after it reaches 0. When the enabling write lands at edge E with reload R, the first `tick_irq` pulse is high in the cycle after edge E+R+1, and later pulses follow every R+1 cycles.
- R5: With source 0, the count advances once per rising edge of `ref_clk`, and it holds while `ref_clk` does not rise.
- R6: The flag is set by the 1-to-0 step. A control/status read returns the flag's value before the read and clears it afterwards.
- R7: `tick_irq` is a single-cycle pulse in the cycle in which the count first reads 0, and only when bit 1 is set. With bit 1 clear, the flag is still set and no pulse appears.
- R8: With a reload of 0 the count stays at 0 and neither the flag nor `tick_irq` is ever raised.
- R9: The reload register keeps bits [23:0] only and reads zero in bits [31:24]. The current-value register also reads zero in [31:24].
- R10: Any write to the current-value register sets the count to 0 and clears the flag. The next counting step loads the reload value and produces no event.
- R11: If a control/status read and a 1-to-0 step fall in the same cycle, the flag is set after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| ref_clk | input | 1 | External reference clock, asynchronous |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while `reg_rd` is high, zero otherwise |
| tick_irq | output | 1 | Single-cycle tick interrupt pulse |

## Verification
Two functions can meet in the same cycle: the clear-on-read of the status flag and the 1-to-0 step that sets it. The bench places a control/status read exactly on the edge where the count from a reload of 3 reaches zero. It expects that read to return the flag clear and a second read to return it set, because the new event must survive the clear. A monitor compares every `tick_irq` pulse with the cycle numbers that the driver queued from the reload value.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int TT_ADDR_W = 2;

  typedef enum logic [TT_ADDR_W-1:0] {
    REG_CTRL    = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_CURRENT = 2'd2,
    REG_SPARE   = 2'd3
  } tt_reg_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int CTRL_SRC_BIT  = 2;
  localparam int CTRL_FLAG_BIT = 16;

  typedef struct packed {
    logic src;   // 1 = system clock, 0 = external reference
    logic ie;    // interrupt enable
    logic en;    // counting enable
  } tt_ctrl_t;
endpackage

// File: rtl/tt_ref_sync.sv
module tt_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic pulse
);
  localparam int MSB = STAGES - 1;

  logic [MSB:0] sync_q;
  logic         last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= ref_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[MSB];
  end

  assign pulse = sync_q[MSB] & ~last_q;

  // R5
  ref_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ie,
  input  logic             src,
  input  logic             ref_pulse,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             evt,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             step;

  assign step = en & (src | ref_pulse);
  assign evt  = step & ~clr & (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= ZERO;
    end else if (clr) begin
      cnt_q <= ZERO;
    end else if (step) begin
      if (cnt_q == ZERO) cnt_q <= reload;
      else               cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= evt & ie;
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));
  // R4
  event_lands_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cnt_q == ZERO));
  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(ie));
  // R7
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R8
  zero_reload_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == ZERO && cnt_q == ZERO) |=> (cnt_q == ZERO));
  // R10
  clear_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == ZERO));
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TT_ADDR_W-1:0] addr,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     cnt_val,
  input  logic                 evt,
  output tt_ctrl_t             ctrl,
  output logic [CNT_W-1:0]     reload,
  output logic                 cur_wr,
  output logic [DATA_W-1:0]    rdata
);
  tt_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             flag_q;
  logic             ctrl_wr, reload_wr, ctrl_rd;
  logic [DATA_W-1:0] mux_d;
  logic             wdata_unused;

  assign ctrl_wr   = wr && (addr == REG_CTRL);
  assign reload_wr = wr && (addr == REG_RELOAD);
  assign cur_wr    = wr && (addr == REG_CURRENT);
  assign ctrl_rd   = rd && (addr == REG_CTRL);
  assign wdata_unused = &{1'b0, wdata[DATA_W-1:CNT_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en  <= wdata[CTRL_EN_BIT];
        ctrl_q.ie  <= wdata[CTRL_IE_BIT];
        ctrl_q.src <= wdata[CTRL_SRC_BIT];
      end
      if (reload_wr) reload_q <= wdata[CNT_W-1:0];
    end
  end

  // a new event outranks the clear, so it is never lost
  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (evt)              flag_q <= 1'b1;
    else if (ctrl_rd || cur_wr) flag_q <= 1'b0;
  end

  always_comb begin
    mux_d = '0;
    case (addr)
      REG_CTRL: begin
        mux_d[CTRL_EN_BIT]   = ctrl_q.en;
        mux_d[CTRL_IE_BIT]   = ctrl_q.ie;
        mux_d[CTRL_SRC_BIT]  = ctrl_q.src;
        mux_d[CTRL_FLAG_BIT] = flag_q;
      end
      REG_RELOAD:  mux_d[CNT_W-1:0] = reload_q;
      REG_CURRENT: mux_d[CNT_W-1:0] = cnt_val;
      default:     mux_d = '0;
    endcase
  end

  assign rdata  = rd ? mux_d : '0;
  assign ctrl   = ctrl_q;
  assign reload = reload_q;

  // R6
  flag_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag_q);
  // R6
  flag_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !evt) |=> !flag_q);
  // R10
  flag_cur_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_wr |=> !flag_q);
  // R11
  flag_collision_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && evt) |=> flag_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_clk,
  input  logic [TT_ADDR_W-1:0] reg_addr,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 tick_irq
);
  tt_ctrl_t         ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cnt;
  logic             cur_wr;
  logic             evt;
  logic             ref_pulse;

  tt_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_in (ref_clk),
    .pulse  (ref_pulse)
  );

  tt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .wdata   (reg_wdata),
    .cnt_val (cnt),
    .evt     (evt),
    .ctrl    (ctrl),
    .reload  (reload),
    .cur_wr  (cur_wr),
    .rdata   (reg_rdata)
  );

  tt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl.en),
    .ie        (ctrl.ie),
    .src       (ctrl.src),
    .ref_pulse (ref_pulse),
    .reload    (reload),
    .clr       (cur_wr),
    .cnt       (cnt),
    .evt       (evt),
    .irq       (tick_irq)
  );

  // R7
  irq_only_when_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_irq |-> $past(ctrl.en));
endmodule

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tick_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_q[$];
  bit done   = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tick_irq(tick_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // all driver tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic ref_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ref_clk = 1'b1; repeat (4) @(negedge clk);
      ref_clk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  // monitor: every irq pulse must match the head of the expected queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic bit exp_now = (exp_q.size() > 0) && (exp_q[0] == cyc);
      if (exp_now || tick_irq) begin
        checks++;
        if (tick_irq !== exp_now) begin
          fails++;
          $display("FAIL R4/R7 irq at cycle %0d: actual %b expected %b", cyc, tick_irq, exp_now);
        end
      end
      if (exp_now) void'(exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    report();
  end

  initial begin
    logic [31:0] d;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(2'd1, d); chk("R1 reload", d, 32'h0);
    rd(2'd2, d); chk("R1 current", d, 32'h0);
    chk("R1 irq", {31'b0, tick_irq}, 32'h0);

    // R2 / R9 reserved bits
    wr(2'd0, 32'hFFFE_FFF8);
    rd(2'd0, d); chk("R2 reserved ctrl bits", d, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk("R9 reload width", d, 32'h00FF_FFFF);
    rd(2'd3, d); chk("R2 spare address", d, 32'h0);

    // R4 / R7 periodic, system clock, reload 4
    wr(2'd1, 32'd4);
    wr(2'd0, 32'h7);
    c0 = cyc;
    exp_q.push_back(c0 + 5); exp_q.push_back(c0 + 10); exp_q.push_back(c0 + 15);
    wait_until(c0 + 2);
    rd(2'd2, d); chk("R4 count falls", d, 32'd3);
    wait_until(c0 + 17);
    wr(2'd0, 32'h6);
    // R3 hold while off
    rd(2'd2, d); chk("R3 held value", d, 32'd2);
    repeat (5) @(negedge clk);
    rd(2'd2, d); chk("R3 still held", d, 32'd2);
    // R6 sticky then clear on read
    rd(2'd0, d); chk("R6 flag set", d, 32'h0001_0006);
    rd(2'd0, d); chk("R6 flag cleared", d, 32'h0000_0006);

    // R7 irq disabled: flag only
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h5);
    c0 = cyc;
    wait_until(c0 + 10);
    wr(2'd0, 32'h4);
    rd(2'd0, d); chk("R7 flag without irq", d, 32'h0001_0004);

    // R8 reload of zero
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h7);
    repeat (20) @(negedge clk);
    rd(2'd2, d); chk("R8 count stays zero", d, 32'h0);
    rd(2'd0, d); chk("R8 no flag", d, 32'h7);
    wr(2'd0, 32'h0);

    // R10 current write clears count and flag, then clean reload
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h5);
    c0 = cyc;
    wait_until(c0 + 4);
    wr(2'd0, 32'h4);
    wr(2'd2, 32'hDEAD_BEEF);
    rd(2'd0, d); chk("R10 flag cleared", d, 32'h4);
    rd(2'd2, d); chk("R10 count zero", d, 32'h0);
    wr(2'd1, 32'd5);
    wr(2'd0, 32'h7);
    c0 = cyc;
    exp_q.push_back(c0 + 6); exp_q.push_back(c0 + 12);
    wait_until(c0 + 1);
    rd(2'd2, d); chk("R10 reload without event", d, 32'd5);
    rd(2'd0, d); chk("R10 no event on reload", d, 32'h7);
    wait_until(c0 + 13);
    wr(2'd0, 32'h6);
    rd(2'd0, d); chk("R4 period six", d, 32'h0001_0006);

    // R11 read and event in the same cycle
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd3);
    wr(2'd0, 32'h5);
    c0 = cyc;
    wait_until(c0 + 3);
    rd(2'd0, d); chk("R11 read before event", d, 32'h5);
    rd(2'd0, d); chk("R11 flag survives", d, 32'h0001_0005);
    wr(2'd0, 32'h0);

    // R5 external reference source
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h1);
    repeat (6) @(negedge clk);
    rd(2'd2, d); chk("R5 no ref edge holds", d, 32'h0);
    ref_edges(4);
    repeat (4) @(negedge clk);
    rd(2'd2, d); chk("R5 four ref edges", d, 32'd97);
    repeat (10) @(negedge clk);
    rd(2'd2, d); chk("R5 idle ref holds", d, 32'd97);
    rd(2'd0, d); chk("R5 no event", d, 32'h1);
    rd(2'd2, d); chk("R9 current width", d & 32'hFF00_0000, 32'h0);

    done = 1'b1;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4 missing irq pulses: actual %0d left expected 0", exp_q.size());
    end
    report();
  end
endmodule